// File: doc/BRIEF.md
# Symbol-Timing NCO with Sync-Loaded Frequency and Phase

This block is a phase accumulator that paces symbol timing. On each enabled clock it adds a frequency increment to a wrapping accumulator. The increment is the active centre frequency plus an optional signed offset frequency. The block reports the accumulator phase plus a phase offset, and it raises a one-cycle wrap flag whenever the accumulator overflows.

A host writes the centre frequency and the phase offset into shadow registers through a small address/data port. These values reach the active registers only on an external sync pulse, and only when the sync feature is enabled. A configuration bit can also make that pulse clear the accumulator, so that the output restarts exactly at the new phase. The offset frequency is written directly and takes effect at once. It can be switched off, or cut down to its top 8, 16, 24 or 32 bits.

Address map: 0 selects configuration, 1 the centre frequency shadow, 2 the phase shadow and 3 the offset frequency. The configuration bits are: bit 5 enables sync loading, bits 4:3 select the offset width, bit 2 enables the offset, and bit 0 clears the accumulator on sync.

Top module: `timing_nco`

## Requirements
- R1: A synchronous active-high reset clears the accumulator, the shadow registers, the active registers and the configuration. After reset, phase_o and wrap_o read 0 and stay 0 while running.
- R2: A write to address 1 (centre frequency shadow) or address 2 (phase shadow) leaves phase_o unchanged until a sync load takes place.
- R3: With configuration bit 5 at 0, a pulse on sync_i leaves the active centre frequency, the phase offset and the accumulator untouched.
- R4: With configuration bit 5 at 1, a pulse on sync_i copies both shadow registers into the active registers. The new phase offset appears on phase_o after the same clock edge.
- R5: With configuration bits 5 and 0 both at 1, a sync pulse clears the accumulator, so phase_o then equals the new phase offset exactly.
- R6: With configuration bit 2 at 0, the offset frequency adds nothing to the increment.
- R7: With configuration bit 2 at 1, the increment includes the top N bits of the offset register (address 3), read as a signed value with the lower bits zero. N is 8, 16, 24 or 32 for field bits 4:3 equal to 00, 01, 10 or 11.
- R8: On each clock with en_i high, the accumulator becomes accumulator + centre + offset modulo 2^ACC_W. phase_o is registered and equals accumulator + phase offset after that edge.
- R9: wrap_o is high for exactly the cycle after an accumulation whose unsigned addition carried out of the top bit, and low otherwise.
- R10: With en_i low and no clearing sync, the accumulator holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | ACC_W | Register write data |
| sync_i | input | 1 | External sync pulse |
| en_i | input | 1 | Accumulate enable |
| phase_o | output | ACC_W | Accumulator plus phase offset |
| wrap_o | output | 1 | Accumulator overflow flag |

## Verification
The bench uses the default ACC_W of 32. At this width all four offset widths fall on byte boundaries, so a hand-computed expected phase can test each width selection directly, including a negative 16-bit offset that brings the phase back to zero. A centre frequency of half the full scale brings the carry-out within reach in two steps. The bench also checks that the shadow registers, a disabled sync and a held enable leave the phase where it was.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_CFG = 2'd0;
  localparam logic [ADDR_W-1:0] A_CF  = 2'd1;
  localparam logic [ADDR_W-1:0] A_PH  = 2'd2;
  localparam logic [ADDR_W-1:0] A_OFS = 2'd3;

  typedef struct packed {
    logic       sync_en;  // bit 5
    logic [1:0] ofs_w;    // bits 4:3
    logic       ofs_en;   // bit 2
    logic       zero_fb;  // bit 0
  } nco_cfg_t;
endpackage

// File: rtl/nco_regs.sv
module nco_regs
  import nco_pkg::*;
#(
  parameter int ACC_W = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [ACC_W-1:0]       wdata_i,
  input  logic                   sync_i,
  output nco_cfg_t               cfg_o,
  output logic [ACC_W-1:0]       cf_o,
  output logic [ACC_W-1:0]       ph_o,
  output logic [ACC_W-1:0]       ph_nxt_o,
  output logic [ACC_W-1:0]       ofs_o,
  output logic                   load_o,
  output logic                   clear_o
);
  nco_cfg_t         cfg_q;
  logic [ACC_W-1:0] cf_hold, ph_hold, cf_act, ph_act, ofs_q;

  assign load_o   = sync_i & cfg_q.sync_en;
  assign clear_o  = load_o & cfg_q.zero_fb;
  assign ph_nxt_o = load_o ? ph_hold : ph_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= '0;
      cf_hold <= '0;
      ph_hold <= '0;
      cf_act  <= '0;
      ph_act  <= '0;
      ofs_q   <= '0;
    end else begin
      if (we_i) begin
        unique case (addr_i)
          A_CFG: cfg_q   <= '{sync_en: wdata_i[5], ofs_w: wdata_i[4:3],
                             ofs_en: wdata_i[2], zero_fb: wdata_i[0]};
          A_CF:  cf_hold <= wdata_i;
          A_PH:  ph_hold <= wdata_i;
          A_OFS: ofs_q   <= wdata_i;
          default: ;
        endcase
      end
      if (load_o) begin
        cf_act <= cf_hold;
        ph_act <= ph_hold;
      end
    end
  end

  assign cfg_o = cfg_q;
  assign cf_o  = cf_act;
  assign ph_o  = ph_act;
  assign ofs_o = ofs_q;

  p_no_load_without_sync_r2: assert property (@(posedge clk) disable iff (rst)
    !load_o |=> $stable(cf_act) && $stable(ph_act));
  p_sync_ignored_r3: assert property (@(posedge clk) disable iff (rst)
    (sync_i && !cfg_q.sync_en) |=> $stable(cf_act) && $stable(ph_act));
  p_sync_loads_r4: assert property (@(posedge clk) disable iff (rst)
    load_o |=> (cf_act == $past(cf_hold)) && (ph_act == $past(ph_hold)));
endmodule

// File: rtl/nco_offset.sv
module nco_offset
  import nco_pkg::*;
#(
  parameter int ACC_W = 32
) (
  input  logic             en_i,
  input  logic [1:0]       width_i,
  input  logic [ACC_W-1:0] ofs_i,
  output logic [ACC_W-1:0] ofs_eff_o
);
  localparam int STEP  = ACC_W / 4;
  localparam int NSEL  = 4;

  logic [ACC_W-1:0] kept [NSEL];

  for (genvar k = 0; k < NSEL; k++) begin : g_width
    localparam logic [ACC_W-1:0] MASK = {ACC_W{1'b1}} << (ACC_W - (k + 1) * STEP);
    assign kept[k] = ofs_i & MASK;
  end

  assign ofs_eff_o = en_i ? kept[width_i] : '0;
endmodule

// File: rtl/nco_accum.sv
module nco_accum #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             clear_i,
  input  logic [ACC_W-1:0] cf_i,
  input  logic [ACC_W-1:0] ofs_i,
  input  logic [ACC_W-1:0] ph_nxt_i,
  output logic [ACC_W-1:0] phase_o,
  output logic             wrap_o
);
  logic [ACC_W-1:0] acc_q, acc_d, incr;
  logic [ACC_W:0]   sum;
  logic             wrap_d;

  assign incr = cf_i + ofs_i;
  assign sum  = {1'b0, acc_q} + {1'b0, incr};

  always_comb begin
    acc_d  = acc_q;
    wrap_d = 1'b0;
    if (clear_i) begin
      acc_d = '0;
    end else if (en_i) begin
      acc_d  = sum[ACC_W-1:0];
      wrap_d = sum[ACC_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      phase_o <= '0;
      wrap_o  <= 1'b0;
    end else begin
      acc_q   <= acc_d;
      phase_o <= acc_d + ph_nxt_i;
      wrap_o  <= wrap_d;
    end
  end

  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (phase_o == '0) && !wrap_o);
  p_zero_on_sync_r5: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> (acc_q == '0) && (phase_o == $past(ph_nxt_i)));
  p_wrap_needs_en_r9: assert property (@(posedge clk) disable iff (rst)
    (!en_i || clear_i) |=> !wrap_o);
  p_hold_when_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (!en_i && !clear_i) |=> $stable(acc_q));
endmodule

// File: rtl/timing_nco.sv
module timing_nco
  import nco_pkg::*;
#(
  parameter int ACC_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [ACC_W-1:0]      wdata_i,
  input  logic                  sync_i,
  input  logic                  en_i,
  output logic [ACC_W-1:0]      phase_o,
  output logic                  wrap_o
);
  nco_cfg_t         cfg;
  logic [ACC_W-1:0] cf, ph, ph_nxt, ofs_raw, ofs_eff;
  logic             load, clear;

  nco_regs #(.ACC_W(ACC_W)) u_regs (
    .clk(clk), .rst(rst), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .sync_i(sync_i), .cfg_o(cfg), .cf_o(cf), .ph_o(ph), .ph_nxt_o(ph_nxt),
    .ofs_o(ofs_raw), .load_o(load), .clear_o(clear)
  );

  nco_offset #(.ACC_W(ACC_W)) u_ofs (
    .en_i(cfg.ofs_en), .width_i(cfg.ofs_w), .ofs_i(ofs_raw), .ofs_eff_o(ofs_eff)
  );

  nco_accum #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst(rst), .en_i(en_i), .clear_i(clear), .cf_i(cf),
    .ofs_i(ofs_eff), .ph_nxt_i(ph_nxt), .phase_o(phase_o), .wrap_o(wrap_o)
  );

  logic unused_ph;
  assign unused_ph = ^ph;
endmodule

// File: tb/tb_timing_nco.sv
module tb_timing_nco;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         we = 1'b0;
  logic [1:0]   addr = '0;
  logic [W-1:0] wdata = '0;
  logic         sync = 1'b0;
  logic         en = 1'b0;
  logic [W-1:0] phase;
  logic         wrap;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  timing_nco #(.ACC_W(W)) dut (
    .clk(clk), .rst(rst), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .sync_i(sync), .en_i(en), .phase_o(phase), .wrap_o(wrap)
  );

  typedef struct packed {
    logic [7:0]   cfg;
    logic [W-1:0] cf;
    logic [W-1:0] ph;
    logic [W-1:0] ofs;
    logic [7:0]   steps;
    logic [W-1:0] exp_ph;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{8'h21, 32'h0000_0100, 32'h0000_0010, 32'h0000_0000, 8'd4, 32'h0000_0410}, // R8 no offset
    '{8'h25, 32'h1000_0000, 32'h0000_0000, 32'h1234_5678, 8'd2, 32'h4400_0000}, // R7 8 bits
    '{8'h2D, 32'h0000_0000, 32'h0003_0000, 32'hFFFF_8001, 8'd3, 32'h0000_0000}, // R7 16 bits signed
    '{8'h35, 32'h0000_0010, 32'h0000_00AB, 32'h0000_01FF, 8'd5, 32'h0000_05FB}, // R7 24 bits
    '{8'h3D, 32'h0000_0001, 32'h0000_0000, 32'h0000_0003, 8'd6, 32'h0000_0018}, // R7 32 bits
    '{8'h39, 32'h0000_0005, 32'h0000_0000, 32'hFFFF_FFFF, 8'd3, 32'h0000_000F}  // R6 offset off
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    we = 1'b1; addr = a; wdata = d;
    tick();
    we = 1'b0;
  endtask

  task automatic pulse_sync();
    sync = 1'b1;
    tick();
    sync = 1'b0;
  endtask

  task automatic step(input int n);
    en = 1'b1;
    for (int i = 0; i < n; i++) tick();
    en = 1'b0;
  endtask

  task automatic chk(input string req, input logic [W-1:0] exp_p, input logic exp_w);
    n_cmp++;
    if (phase !== exp_p || wrap !== exp_w) begin
      n_bad++;
      $display("FAIL %s: phase=%h wrap=%b expected phase=%h wrap=%b", req, phase, wrap, exp_p, exp_w);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic [W-1:0] exp_p;
    tick(); tick();
    rst = 1'b0;
    tick();
    chk("R1 reset state", '0, 1'b0);

    for (int v = 0; v < NV; v++) begin
      wr(2'd0, {24'd0, VEC[v].cfg});
      wr(2'd1, VEC[v].cf);
      wr(2'd2, VEC[v].ph);
      wr(2'd3, VEC[v].ofs);
      pulse_sync();
      chk("R5 clear on sync", VEC[v].ph, 1'b0);
      step(int'(VEC[v].steps));
      n_cmp++;
      if (phase !== VEC[v].exp_ph) begin
        n_bad++;
        $display("FAIL R8/R7/R6 vector %0d: phase=%h expected %h", v, phase, VEC[v].exp_ph);
      end
    end

    // R2: shadow writes do not reach the output; acc=15, cf=5, ph=0
    wr(2'd1, 32'h100);
    wr(2'd2, 32'h7);
    chk("R2 shadow write", 32'hF, 1'b0);
    step(1);
    chk("R2 old freq kept", 32'h14, 1'b0);

    // R3: sync disabled
    wr(2'd0, 32'h19);
    pulse_sync();
    chk("R3 sync ignored", 32'h14, 1'b0);
    step(1);
    chk("R3 old freq still", 32'h19, 1'b0);

    // R4: sync loads without clearing
    wr(2'd0, 32'h20);
    pulse_sync();
    chk("R4 phase loaded", 32'h20, 1'b0);
    step(1);
    chk("R4 freq loaded", 32'h120, 1'b0);

    // R10: enable low holds
    tick(); tick();
    chk("R10 hold", 32'h120, 1'b0);

    // R9: carry out
    wr(2'd0, 32'h21);
    wr(2'd1, 32'h8000_0000);
    wr(2'd2, 32'h0);
    pulse_sync();
    chk("R5 cleared", 32'h0, 1'b0);
    exp_p = 32'h8000_0000;
    step(1);
    chk("R9 no carry", exp_p, 1'b0);
    step(1);
    chk("R9 carry", 32'h0, 1'b1);
    tick();
    chk("R9 flag one cycle", 32'h0, 1'b0);
    step(1);
    chk("R9 no carry again", exp_p, 1'b0);

    // R1: reset mid run clears everything
    rst = 1'b1;
    tick();
    rst = 1'b0;
    chk("R1 reset clears", '0, 1'b0);
    step(3);
    chk("R1 freq cleared", '0, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule